// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block turns a list of source descriptors held in memory into a stream of segment requests for a hashing datapath. A single `start` pulse hands it the base address of the list. It then reads each 8-byte descriptor through a simple 32-bit read port. Each descriptor holds a length word followed by an address word. The block presents the decoded byte address and byte length downstream over a valid/ready handshake.

The read port allows one outstanding read at a time. A read is issued with `rd_req` and accepted on `rd_ready`, and the data comes back later with `rd_valid`. Each returned word is already assembled little-endian, so the byte at the lowest address sits in bits 7:0. The walk stops after the descriptor whose length word has its top bit set. It also stops after a parameterised maximum number of entries, and in that case it flags the walk as overrun. A single-cycle completion pulse reports the end of the walk together with the number of segments issued.

Top module: `sg_list_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `rd_req`, `seg_valid` and `walk_done` are low, and `seg_count` is 0.
- R2: For descriptor k, counted from 0, the block reads the length word at `list_base + 8*k` and then the address word at `list_base + 8*k + 4`, with arithmetic modulo 2^32. It never has more than one read outstanding, and it holds `rd_req` and `rd_addr` steady until `rd_ready`.
- R3: `seg_len` is bits 27:0 of the length word. `seg_addr` is the address word with bit 31 forced to 0.
- R4: `seg_last` equals bit 31 of the length word. Once a segment with `seg_last` high is accepted, no further reads are made and the walk ends without an overrun.
- R5: A segment is offered only after both words of its descriptor have returned. While `seg_valid` is high and `seg_ready` is low, `seg_addr`, `seg_len` and `seg_last` do not change.
- R6: If MAX_ENTRIES segments have been accepted and none carried the last flag, the walk ends with `limit_err` high and `seg_count` equal to MAX_ENTRIES, and no descriptor beyond that limit is read.
- R7: `walk_done` is high for exactly one cycle, the cycle after the final segment handshake. In that cycle `seg_count` equals the number of segments accepted. `seg_count` and `limit_err` then hold their values until the next accepted `start`.
- R8: A `start` pulse while `busy` is high is ignored: the walk in progress continues with its original base address.
- R9: A descriptor whose length field is 0 is still issued as a segment of length 0.
- R10: A `rd_valid` pulse while no read is outstanding is ignored and does not change any segment that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk; sampled only while idle |
| list_base | input | ADDR_W | Byte address of descriptor 0 |
| rd_req | output | 1 | Read request valid |
| rd_addr | output | ADDR_W | Byte address of the word requested |
| rd_ready | input | 1 | Read request accepted |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 32 | Returned word, little-endian assembled |
| seg_valid | output | 1 | Segment request valid |
| seg_ready | input | 1 | Segment request accepted |
| seg_addr | output | ADDR_W | Segment byte address (bit 31 cleared) |
| seg_len | output | LEN_W | Segment byte length |
| seg_last | output | 1 | Segment came from the final descriptor |
| busy | output | 1 | A walk is in progress |
| walk_done | output | 1 | One-cycle end-of-walk pulse |
| limit_err | output | 1 | Walk ended at the entry limit without a last flag |
| seg_count | output | CNT_W | Segments accepted in the current or latest walk |

## Verification
The bench goes after four corner cases. The first is a last flag on the very entry where the limit is reached: a design that tests the limit before the flag would raise `limit_err` there by mistake. The second is a list with no last flag at all: an off-by-one in the limit compare would show up as a 31st or 33rd segment, or as a read of a descriptor past the limit. The third is a length word with bits 28 to 30 set and an address word with bit 31 set: wrong masking would leak those bits into `seg_len` or `seg_addr`. The fourth is a list based just below the top of the address space: a design that does not wrap correctly would fetch from the wrong address. Throughout, the bench throttles both ready signals and adds read latency, which exposes a segment that changes while stalled. It also sends stray `rd_valid` pulses, which catch a design that captures a word outside its wait state. It sends restart pulses mid-walk, which catch a design that reloads its base address while busy.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_BYTES = 8;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int LAST_BIT   = 31;

    typedef enum logic [2:0] {
        SG_IDLE,
        SG_LEN_REQ,
        SG_LEN_WAIT,
        SG_ADR_REQ,
        SG_ADR_WAIT,
        SG_EMIT,
        SG_FINISH
    } sg_state_e;
endpackage

// File: rtl/sgw_addr_gen.sv
module sgw_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic              word_sel,
    output logic [ADDR_W-1:0] word_addr
);
    localparam int STRIDE_SH = $clog2(sgw_pkg::DESC_BYTES);

    logic [ADDR_W-1:0] entry_off;
    logic [ADDR_W-1:0] word_off;

    always_comb begin
        entry_off = ADDR_W'(idx) << STRIDE_SH;
        word_off  = word_sel ? ADDR_W'(sgw_pkg::WORD_BYTES) : '0;
        word_addr = base + entry_off + word_off;
    end
endmodule

// File: rtl/sgw_word_unpack.sv
module sgw_word_unpack #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 28,
    parameter int KEEP_ADDR_W = 31
) (
    input  logic [sgw_pkg::WORD_W-1:0] len_word,
    input  logic [sgw_pkg::WORD_W-1:0] adr_word,
    output logic [LEN_W-1:0]           byte_len,
    output logic                       is_last,
    output logic [ADDR_W-1:0]          byte_addr
);
    assign byte_len = len_word[LEN_W-1:0];
    assign is_last  = len_word[sgw_pkg::LAST_BIT];

    generate
        if (KEEP_ADDR_W >= ADDR_W) begin : g_addr_full
            assign byte_addr = adr_word[ADDR_W-1:0];
        end else begin : g_addr_trim
            assign byte_addr = {{(ADDR_W-KEEP_ADDR_W){1'b0}}, adr_word[KEEP_ADDR_W-1:0]};
        end
    endgenerate
endmodule

// File: rtl/sg_list_walker.sv
module sg_list_walker #(
    parameter int MAX_ENTRIES = 32,
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 28,
    parameter int KEEP_ADDR_W = 31,
    localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [ADDR_W-1:0]          list_base,
    output logic                       rd_req,
    output logic [ADDR_W-1:0]          rd_addr,
    input  logic                       rd_ready,
    input  logic                       rd_valid,
    input  logic [sgw_pkg::WORD_W-1:0] rd_data,
    output logic                       seg_valid,
    input  logic                       seg_ready,
    output logic [ADDR_W-1:0]          seg_addr,
    output logic [LEN_W-1:0]           seg_len,
    output logic                       seg_last,
    output logic                       busy,
    output logic                       walk_done,
    output logic                       limit_err,
    output logic [CNT_W-1:0]           seg_count
);
    import sgw_pkg::*;

    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_ENTRIES);

    typedef struct packed {
        sg_state_e         state;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] len_raw;
        logic [WORD_W-1:0] adr_raw;
        logic              err;
    } walk_regs_t;

    walk_regs_t r_q, r_d;
    logic [CNT_W-1:0] cnt_inc;
    logic             cur_last;

    sgw_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(CNT_W)) u_addr (
        .base      (r_q.base),
        .idx       (r_q.cnt),
        .word_sel  (r_q.state == SG_ADR_REQ),
        .word_addr (rd_addr)
    );

    sgw_word_unpack #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .KEEP_ADDR_W(KEEP_ADDR_W)) u_unpack (
        .len_word  (r_q.len_raw),
        .adr_word  (r_q.adr_raw),
        .byte_len  (seg_len),
        .is_last   (cur_last),
        .byte_addr (seg_addr)
    );

    always_comb begin
        r_d     = r_q;
        cnt_inc = r_q.cnt + CNT_W'(1);
        unique case (r_q.state)
            SG_IDLE: begin
                if (start) begin
                    r_d.base  = list_base;
                    r_d.cnt   = '0;
                    r_d.err   = 1'b0;
                    r_d.state = SG_LEN_REQ;
                end
            end
            SG_LEN_REQ: begin
                if (rd_ready) r_d.state = SG_LEN_WAIT;
            end
            SG_LEN_WAIT: begin
                if (rd_valid) begin
                    r_d.len_raw = rd_data;
                    r_d.state   = SG_ADR_REQ;
                end
            end
            SG_ADR_REQ: begin
                if (rd_ready) r_d.state = SG_ADR_WAIT;
            end
            SG_ADR_WAIT: begin
                if (rd_valid) begin
                    r_d.adr_raw = rd_data;
                    r_d.state   = SG_EMIT;
                end
            end
            SG_EMIT: begin
                if (seg_ready) begin
                    r_d.cnt = cnt_inc;
                    if (cur_last) begin
                        r_d.state = SG_FINISH;
                    end else if (cnt_inc == CNT_LIMIT) begin
                        r_d.err   = 1'b1;
                        r_d.state = SG_FINISH;
                    end else begin
                        r_d.state = SG_LEN_REQ;
                    end
                end
            end
            SG_FINISH: r_d.state = SG_IDLE;
            default:   r_d.state = SG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: SG_IDLE, base: '0, cnt: '0, len_raw: '0, adr_raw: '0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req    = (r_q.state == SG_LEN_REQ) || (r_q.state == SG_ADR_REQ);
    assign seg_valid = (r_q.state == SG_EMIT);
    assign seg_last  = cur_last;
    assign busy      = (r_q.state != SG_IDLE);
    assign walk_done = (r_q.state == SG_FINISH);
    assign limit_err = r_q.err;
    assign seg_count = r_q.cnt;

    // R5
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_last));

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ready |=> rd_req && $stable(rd_addr));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done);

    // R7
    done_after_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> $past(seg_valid && seg_ready));

    // R4
    last_ends_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && seg_ready && seg_last |=> walk_done && !limit_err);

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_count <= CNT_LIMIT);
endmodule

// File: tb/sg_list_walker_test.sv
module sg_list_walker_test;
    localparam int MAXE = 32;
    localparam int CW   = $clog2(MAXE + 1);

    typedef struct {
        logic [31:0] a;
        logic [27:0] l;
        logic        lst;
    } seg_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] list_base = '0;
    logic        rd_req, rd_ready = 1'b0, rd_valid = 1'b0;
    logic [31:0] rd_addr, rd_data = '0;
    logic        seg_valid, seg_ready = 1'b0, seg_last;
    logic [31:0] seg_addr;
    logic [27:0] seg_len;
    logic        busy, walk_done, limit_err;
    logic [CW-1:0] seg_count;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] exp_rd [$];
    seg_t        exp_seg [$];
    int          exp_count = 0;
    bit          exp_err = 0;
    bit          junk_on = 0;
    int          done_seen = 0;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    sg_list_walker #(.MAX_ENTRIES(MAXE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_last(seg_last), .busy(busy),
        .walk_done(walk_done), .limit_err(limit_err), .seg_count(seg_count)
    );

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    // Monitor, responder and reference comparison, evaluated on every clock.
    initial begin : monitor
        bit          pending = 0;
        int          lat = 0;
        logic [31:0] pend_addr = '0;
        bit          have_res = 0;
        logic [CW-1:0] res_cnt = '0;
        logic        res_err = 0;
        int          cyc = 0;
        seg_t        e;
        logic [31:0] ea;
        wait (rst_n);
        @(negedge clk);
        // R1
        chk(!busy && !rd_req && !seg_valid && !walk_done && seg_count == 0, "R1 reset idle",
            {busy, rd_req, seg_valid, walk_done, 8'(seg_count)}, 0);
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
            // read response side (R2, R10)
            rd_valid = 1'b0;
            rd_data  = $urandom;
            if (pending) begin
                if (lat == 0) begin
                    rd_valid = 1'b1;
                    rd_data  = mem_rd(pend_addr);
                    pending  = 0;
                end else lat--;
            end else if (junk_on && ($urandom % 4 == 0)) begin
                rd_valid = 1'b1;
                rd_data  = 32'hDEAD_BEEF;
            end
            rd_ready = ($urandom % 3 != 0);
            if (rd_req && rd_ready) begin
                // R2
                chk(!pending, "R2 single outstanding read", pending, 0);
                if (exp_rd.size() == 0) begin
                    chk(0, "R2 unexpected read", rd_addr, 0);
                end else begin
                    ea = exp_rd.pop_front();
                    chk(rd_addr == ea, "R2 read address", rd_addr, ea);
                end
                pending   = 1;
                pend_addr = rd_addr;
                lat       = $urandom % 3;
            end
            // segment side (R3, R4, R5, R9, R10)
            seg_ready = ($urandom % 4 != 0);
            if (seg_valid && seg_ready) begin
                if (exp_seg.size() == 0) begin
                    chk(0, "R4 segment after end", seg_addr, 0);
                end else begin
                    e = exp_seg.pop_front();
                    chk(seg_addr == e.a, "R3 segment address", seg_addr, e.a);
                    chk(seg_len == e.l, "R3 R9 segment length", seg_len, e.l);
                    chk(seg_last == e.lst, "R4 last flag", seg_last, e.lst);
                end
            end
            // completion (R6, R7)
            if (walk_done) begin
                chk(seg_count == CW'(exp_count), "R7 segment count at done", seg_count, exp_count);
                chk(limit_err == exp_err, "R6 limit error at done", limit_err, exp_err);
                chk(exp_seg.size() == 0, "R7 all segments before done", exp_seg.size(), 0);
                chk(exp_rd.size() == 0, "R6 all reads before done", exp_rd.size(), 0);
                have_res = 1;
                res_cnt  = seg_count;
                res_err  = limit_err;
                done_seen++;
            end else if (!busy && have_res) begin
                // R7
                chk(seg_count == res_cnt && limit_err == res_err, "R7 result held while idle",
                    {limit_err, 8'(seg_count)}, {res_err, 8'(res_cnt)});
            end
            if (busy && !walk_done) have_res = 0;
        end
    end

    // Reference expectation built from the requirements.
    task automatic expect_walk(input logic [31:0] base);
        logic [31:0] a, lw, dw;
        seg_t s;
        exp_rd.delete();
        exp_seg.delete();
        for (int k = 0; k < MAXE; k++) begin
            a  = base + 32'(k * 8);
            lw = mem_rd(a);
            dw = mem_rd(a + 32'd4);
            exp_rd.push_back(a);
            exp_rd.push_back(a + 32'd4);
            s.a   = {1'b0, dw[30:0]};
            s.l   = lw[27:0];
            s.lst = lw[31];
            exp_seg.push_back(s);
            exp_count = k + 1;
            exp_err   = 0;
            if (lw[31]) break;
            if (k + 1 == MAXE) exp_err = 1;
        end
    endtask

    task automatic put(input logic [31:0] base, input int k, input logic [31:0] lw, input logic [31:0] aw);
        mem[base + 32'(k * 8)]      = lw;
        mem[base + 32'(k * 8) + 4]  = aw;
    endtask

    task automatic run(input logic [31:0] base, input int restart_at);
        int seen;
        expect_walk(base);
        seen = done_seen;
        @(negedge clk);
        start = 1'b1;
        list_base = base;
        @(negedge clk);
        start = 1'b0;
        list_base = 32'h0BAD_0000;
        for (int c = 0; done_seen == seen; c++) begin
            if (restart_at > 0 && (c == restart_at || c == restart_at * 3)) begin
                start = 1'b1;   // R8: must be ignored while busy
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R4: masking of upper length bits and address bit 31, single last entry
        mem.delete();
        put(32'h0000_1000, 0, 32'hF000_0040, 32'hFFFF_FF00);
        run(32'h0000_1000, 0);

        // R2 R4 R9: five entries, zero length in the middle
        mem.delete();
        put(32'h0000_2000, 0, 32'h0000_0100, 32'h1000_0000);
        put(32'h0000_2000, 1, 32'h0FFF_FFFF, 32'h8000_0004);
        put(32'h0000_2000, 2, 32'h0000_0000, 32'h2222_2220);
        put(32'h0000_2000, 3, 32'h7000_0003, 32'h3333_3333);
        put(32'h0000_2000, 4, 32'h8000_0010, 32'h4444_4440);
        put(32'h0000_2000, 5, 32'h0000_0999, 32'h5555_5550);
        run(32'h0000_2000, 0);

        // R8 R10: restart pulses and stray read responses during a walk
        junk_on = 1;
        mem.delete();
        for (int k = 0; k < 7; k++) put(32'h0000_3000, k, 32'(k * 16 + 1), 32'h0100_0000 + 32'(k * 64));
        put(32'h0000_3000, 7, 32'h8000_0077, 32'h0700_0000);
        put(32'h0BAD_0000, 0, 32'h8000_0001, 32'h0000_0001);
        run(32'h0000_3000, 3);

        // R2: list straddling the top of the address space
        mem.delete();
        put(32'hFFFF_FFF0, 0, 32'h0000_0020, 32'h0000_A000);
        put(32'hFFFF_FFF0, 1, 32'h0000_0030, 32'h0000_B000);
        put(32'hFFFF_FFF0, 2, 32'h8000_0040, 32'h0000_C000);
        run(32'hFFFF_FFF0, 0);
        junk_on = 0;

        // R6: no last flag anywhere; limit ends the walk
        mem.delete();
        for (int k = 0; k < MAXE + 2; k++) put(32'h0001_0000, k, 32'(k + 5), 32'h0020_0000 + 32'(k * 8));
        run(32'h0001_0000, 0);

        // R4 R6: last flag on exactly the limit entry is not an overrun
        mem.delete();
        for (int k = 0; k < MAXE - 1; k++) put(32'h0002_0000, k, 32'(k + 9), 32'h0030_0000 + 32'(k * 8));
        put(32'h0002_0000, MAXE - 1, 32'h8000_0123, 32'h0040_0000);
        run(32'h0002_0000, 0);

        // R7: results stay put over a longer idle period
        repeat (20) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule